// File: doc/BRIEF.md
# Windowed Register File with Overlapping Call Frames

This block is a register file for a processor that gives each procedure its own register window instead of saving registers to memory on every call. Storage is a flat array of physical registers. The default has 74 registers of 32 bits. One group of them is global and the rest form a ring of windows. Every instruction sees a 32-entry logical view, addressed with a 5-bit register number. A current-window pointer selects which slice of the ring backs that view.

Adjacent windows share a group of registers. A caller places arguments in its outgoing group. After a call pulse the callee finds the same physical registers in its incoming group, and results return the same way after a return pulse. Nothing is copied. The block offers two combinational read ports and one clocked write port.

The block also tracks how many windows are live. A call that would wrap onto the oldest live window is refused and raises an overflow flag. A return with no outstanding call is refused and raises an underflow flag. Spilling and filling windows in memory is left to the surrounding processor.

Top module: `winreg_file`

## Requirements
- R1: After reset the window pointer is 0, both flags are low, and every logical register reads 0 on both read ports.
- R2: Logical registers 0 to 9 address the same ten global registers whatever the window pointer holds.
- R3: Logical registers 16 to 25 are private to each window. A write made in one window is not seen at those numbers in another window.
- R4: Logical registers 26 to 31 of window w are the same physical registers as logical registers 10 to 15 of window w+1, in the same order.
- R5: A call pulse advances the window pointer by one, and a return pulse moves it back by one, each at the next clock edge.
- R6: With NUM_WIN-1 calls outstanding, a call raises the overflow flag combinationally in that cycle and leaves the pointer unchanged.
- R7: With no call outstanding, a return raises the underflow flag combinationally in that cycle and leaves the pointer unchanged.
- R8: Call and return asserted in the same cycle have no effect on the pointer and raise no flag.
- R9: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value appears after the clock edge.
- R10: A write issued in the same cycle as an accepted call is decoded with the window in force before the call.
- R11: Window offsets wrap around the ring, so logical 26 to 31 of the last window alias logical 10 to 15 of window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Call pulse: advance to the next window |
| ret_i | input | 1 | Return pulse: go back to the previous window |
| rd_a_idx | input | 5 | Logical register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 5 | Logical register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical register number for the write |
| wr_data | input | 32 | Write data |
| cwp_o | output | 2 | Current window pointer |
| ovf_o | output | 1 | Call refused: window overflow |
| unf_o | output | 1 | Return refused: window underflow |

## Verification
A write and a window move can land on the same clock edge. The two must not interfere: the write has to be decoded through the window that was current before the edge. To provoke this, the bench issues a call while it writes outgoing register 26. After the edge it reads incoming register 10 in the new window and expects the written value there. A second collision, call and return in the same cycle, is judged by a pointer that does not move and by flags that stay low.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

   localparam int DEF_DATA_W  = 32;
   localparam int DEF_GLOBALS = 10;
   localparam int DEF_LOCALS  = 10;
   localparam int DEF_COMMON  = 6;
   localparam int DEF_WINDOWS = 4;
   localparam int DEF_IDX_W   = 5;

   // Translate a logical register number, seen from window cwp, into a
   // physical register index. Globals are not windowed; everything above
   // them is an offset into the ring of (locals + common) registers per window.
   function automatic int phys_of(int cwp, int idx, int g, int l, int c, int w);
      int ring;
      int sum;
      ring = w * (l + c);
      if (idx < g) return idx;
      sum = cwp * (l + c) + (idx - g);
      if (sum >= ring) sum = sum - ring;
      return g + sum;
   endfunction

endpackage

// File: rtl/wrf_map.sv
module wrf_map #(
   parameter int GLOBALS = wrf_pkg::DEF_GLOBALS,
   parameter int LOCALS  = wrf_pkg::DEF_LOCALS,
   parameter int COMMON  = wrf_pkg::DEF_COMMON,
   parameter int WINDOWS = wrf_pkg::DEF_WINDOWS,
   parameter int IDX_W   = wrf_pkg::DEF_IDX_W,
   parameter int CWP_W   = 2,
   parameter int PHYS_W  = 7
) (
   input  logic [CWP_W-1:0]  cwp_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [PHYS_W-1:0] phys_o
);

   always_comb begin
      phys_o = PHYS_W'(wrf_pkg::phys_of(int'(cwp_i), int'(idx_i),
                                        GLOBALS, LOCALS, COMMON, WINDOWS));
   end

endmodule

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl #(
   parameter int WINDOWS = wrf_pkg::DEF_WINDOWS,
   parameter int CWP_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             call_i,
   input  logic             ret_i,
   output logic [CWP_W-1:0] cwp_o,
   output logic             call_ok_o,
   output logic             ovf_o,
   output logic             unf_o
);

   localparam int NEST_W   = $clog2(WINDOWS);
   localparam int MAX_NEST = WINDOWS - 1;

   logic [CWP_W-1:0]  cwp_q;
   logic [NEST_W-1:0] nest_q;
   logic              call_only, ret_only, at_top, at_bottom, call_ok, ret_ok;

   always_comb begin
      call_only = call_i & ~ret_i;
      ret_only  = ret_i & ~call_i;
      at_top    = (nest_q == NEST_W'(MAX_NEST));
      at_bottom = (nest_q == '0);
      call_ok   = call_only & ~at_top;
      ret_ok    = ret_only & ~at_bottom;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cwp_q  <= '0;
         nest_q <= '0;
      end else if (call_ok) begin
         cwp_q  <= (cwp_q == CWP_W'(WINDOWS - 1)) ? '0 : cwp_q + 1'b1;
         nest_q <= nest_q + 1'b1;
      end else if (ret_ok) begin
         cwp_q  <= (cwp_q == '0) ? CWP_W'(WINDOWS - 1) : cwp_q - 1'b1;
         nest_q <= nest_q - 1'b1;
      end
   end

   assign cwp_o     = cwp_q;
   assign call_ok_o = call_ok;
   assign ovf_o     = call_only & at_top;
   assign unf_o     = ret_only & at_bottom;

   // R6
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> $stable(cwp_o));
   // R7
   unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o |=> $stable(cwp_o));
   // R8
   both_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && ret_i) |-> !ovf_o && !unf_o);
   // R5
   call_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !ret_i && !ovf_o) |=>
         int'(cwp_o) == (int'($past(cwp_o)) + 1) % WINDOWS);

endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
   parameter int DATA_W     = wrf_pkg::DEF_DATA_W,
   parameter int PHYS_N     = 74,
   parameter int PHYS_W     = 7,
   parameter bit RESET_REGS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [PHYS_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [PHYS_W-1:0] raddr_a_i,
   input  logic [PHYS_W-1:0] raddr_b_i,
   output logic [DATA_W-1:0] rdata_a_o,
   output logic [DATA_W-1:0] rdata_b_o
);

   logic [DATA_W-1:0] regs [PHYS_N];

   generate
      if (RESET_REGS) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < PHYS_N; i++) regs[i] <= '0;
            end else if (we_i) begin
               regs[waddr_i] <= wdata_i;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we_i) regs[waddr_i] <= wdata_i;
         end
      end
   endgenerate

   assign rdata_a_o = regs[raddr_a_i];
   assign rdata_b_o = regs[raddr_b_i];

   // R9
   wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> regs[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
   parameter int DATA_W     = wrf_pkg::DEF_DATA_W,
   parameter int GLOBALS    = wrf_pkg::DEF_GLOBALS,
   parameter int LOCALS     = wrf_pkg::DEF_LOCALS,
   parameter int COMMON     = wrf_pkg::DEF_COMMON,
   parameter int WINDOWS    = wrf_pkg::DEF_WINDOWS,
   parameter int IDX_W      = wrf_pkg::DEF_IDX_W,
   parameter bit RESET_REGS = 1'b1,
   localparam int CWP_W     = $clog2(WINDOWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CWP_W-1:0]  cwp_o,
   output logic              ovf_o,
   output logic              unf_o
);

   localparam int PHYS_N = (LOCALS + COMMON) * WINDOWS + GLOBALS;
   localparam int PHYS_W = $clog2(PHYS_N);
   localparam int VIEW_N = GLOBALS + LOCALS + 2 * COMMON;

   initial begin : param_chk
      assert (VIEW_N == (1 << IDX_W))
         else $fatal(1, "window view must fill the logical index space");
      assert (WINDOWS >= 2) else $fatal(1, "at least two windows needed");
      assert (COMMON >= 1 && LOCALS >= 1) else $fatal(1, "empty window groups");
   end

   logic [CWP_W-1:0]  cwp;
   logic              call_ok;
   logic [PHYS_W-1:0] phys_a, phys_b, phys_w;
   logic [IDX_W-1:0]  idx_port [3];
   logic [PHYS_W-1:0] phys_port [3];

   assign idx_port[0] = rd_a_idx;
   assign idx_port[1] = rd_b_idx;
   assign idx_port[2] = wr_idx;

   wrf_window_ctrl #(.WINDOWS(WINDOWS), .CWP_W(CWP_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
      .cwp_o(cwp), .call_ok_o(call_ok), .ovf_o(ovf_o), .unf_o(unf_o));

   // One translator per port; all share the pre-edge window pointer, so a
   // write issued with a call lands in the caller's frame.
   for (genvar p = 0; p < 3; p++) begin : g_map
      wrf_map #(.GLOBALS(GLOBALS), .LOCALS(LOCALS), .COMMON(COMMON),
                .WINDOWS(WINDOWS), .IDX_W(IDX_W), .CWP_W(CWP_W),
                .PHYS_W(PHYS_W)) u_map (
         .cwp_i(cwp), .idx_i(idx_port[p]), .phys_o(phys_port[p]));
   end

   assign phys_a = phys_port[0];
   assign phys_b = phys_port[1];
   assign phys_w = phys_port[2];

   wrf_storage #(.DATA_W(DATA_W), .PHYS_N(PHYS_N), .PHYS_W(PHYS_W),
                 .RESET_REGS(RESET_REGS)) u_store (
      .clk(clk), .rst_n(rst_n), .we_i(wr_en), .waddr_i(phys_w),
      .wdata_i(wr_data), .raddr_a_i(phys_a), .raddr_b_i(phys_b),
      .rdata_a_o(rd_a_data), .rdata_b_o(rd_b_data));

   assign cwp_o = cwp;

   // R2
   glob_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_a_idx) < GLOBALS) |-> int'(phys_a) == int'(rd_a_idx));
   // R11
   map_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(phys_w) < PHYS_N && int'(phys_a) < PHYS_N && int'(phys_b) < PHYS_N);
   // R10
   call_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_ok && wr_en) |=> $past(cwp) != cwp);

endmodule

// File: tb/sim_winreg_file.sv
module sim_winreg_file;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_i = 1'b0, ret_i = 1'b0, wr_en = 1'b0;
   logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_a_data, rd_b_data;
   logic [1:0]  cwp_o;
   logic        ovf_o, unf_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   winreg_file u0 (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o));

   typedef struct packed {
      logic        call;
      logic        ret;
      logic        we;
      logic [4:0]  widx;
      logic [31:0] wdata;
      logic [4:0]  ridx;
      logic [31:0] rexp;
      logic [1:0]  cwp;
      logic        ovf;
      logic        unf;
      logic [3:0]  req;
   } vec_t;

   // Expectations are the state seen before the clock edge of each step.
   localparam int NV = 19;
   localparam vec_t TBL [NV] = '{
      '{1'b0,1'b0,1'b1,5'd3, 32'h11,5'd3, 32'h0, 2'd0,1'b0,1'b0,4'd9},  // R9 old value
      '{1'b0,1'b0,1'b1,5'd20,32'hA0,5'd3, 32'h11,2'd0,1'b0,1'b0,4'd9},  // R9 new value
      '{1'b0,1'b0,1'b1,5'd28,32'hB0,5'd20,32'hA0,2'd0,1'b0,1'b0,4'd3},  // R3
      '{1'b1,1'b0,1'b0,5'd0, 32'h0, 5'd28,32'hB0,2'd0,1'b0,1'b0,4'd5},  // R5 call
      '{1'b0,1'b0,1'b0,5'd0, 32'h0, 5'd12,32'hB0,2'd1,1'b0,1'b0,4'd4},  // R4
      '{1'b0,1'b0,1'b1,5'd11,32'hC1,5'd20,32'h0, 2'd1,1'b0,1'b0,4'd3},  // R3 private
      '{1'b0,1'b0,1'b1,5'd20,32'hA1,5'd3, 32'h11,2'd1,1'b0,1'b0,4'd2},  // R2
      '{1'b1,1'b0,1'b1,5'd26,32'hD1,5'd20,32'hA1,2'd1,1'b0,1'b0,4'd10}, // R10
      '{1'b0,1'b0,1'b0,5'd0, 32'h0, 5'd10,32'hD1,2'd2,1'b0,1'b0,4'd10}, // R10
      '{1'b1,1'b0,1'b0,5'd0, 32'h0, 5'd3, 32'h11,2'd2,1'b0,1'b0,4'd2},  // R2
      '{1'b0,1'b0,1'b1,5'd29,32'hE3,5'd20,32'h0, 2'd3,1'b0,1'b0,4'd3},  // R3
      '{1'b1,1'b0,1'b0,5'd0, 32'h0, 5'd29,32'hE3,2'd3,1'b1,1'b0,4'd6},  // R6
      '{1'b0,1'b1,1'b0,5'd0, 32'h0, 5'd20,32'h0, 2'd3,1'b0,1'b0,4'd6},  // R6 held
      '{1'b0,1'b1,1'b0,5'd0, 32'h0, 5'd10,32'hD1,2'd2,1'b0,1'b0,4'd5},  // R5 ret
      '{1'b1,1'b1,1'b0,5'd0, 32'h0, 5'd11,32'hC1,2'd1,1'b0,1'b0,4'd8},  // R8
      '{1'b0,1'b1,1'b0,5'd0, 32'h0, 5'd11,32'hC1,2'd1,1'b0,1'b0,4'd8},  // R8 held
      '{1'b0,1'b0,1'b0,5'd0, 32'h0, 5'd13,32'hE3,2'd0,1'b0,1'b0,4'd11}, // R11
      '{1'b0,1'b1,1'b0,5'd0, 32'h0, 5'd27,32'hC1,2'd0,1'b0,1'b1,4'd7},  // R7
      '{1'b0,1'b0,1'b0,5'd0, 32'h0, 5'd28,32'hB0,2'd0,1'b0,1'b0,4'd7}   // R7 held
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      call_i = 1'b0; ret_i = 1'b0; wr_en = 1'b0;
   endtask

   initial begin
      idle();
      repeat (2) @(negedge clk);
      // R1: reset state
      #2;
      chk("R1 cwp", 32'(cwp_o), 32'd0);
      chk("R1 flags", {30'd0, ovf_o, unf_o}, 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i);
         #2;
         chk("R1 port a", rd_a_data, 32'd0);
         chk("R1 port b", rd_b_data, 32'd0);
      end

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         call_i = TBL[v].call; ret_i = TBL[v].ret; wr_en = TBL[v].we;
         wr_idx = TBL[v].widx; wr_data = TBL[v].wdata;
         rd_a_idx = TBL[v].ridx; rd_b_idx = TBL[v].ridx;
         #2;
         chk($sformatf("R%0d step %0d rd_a", TBL[v].req, v), rd_a_data, TBL[v].rexp);
         chk($sformatf("R%0d step %0d rd_b", TBL[v].req, v), rd_b_data, TBL[v].rexp);
         chk($sformatf("R%0d step %0d cwp", TBL[v].req, v), 32'(cwp_o), 32'(TBL[v].cwp));
         chk($sformatf("R%0d step %0d ovf", TBL[v].req, v), 32'(ovf_o), 32'(TBL[v].ovf));
         chk($sformatf("R%0d step %0d unf", TBL[v].req, v), 32'(unf_o), 32'(TBL[v].unf));
      end
      @(negedge clk);
      idle();

      // R8 directed: simultaneous call and return at the overflow boundary
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); call_i = 1'b1;
      end
      @(negedge clk); call_i = 1'b1; ret_i = 1'b1;
      #2;
      chk("R8 no ovf", 32'(ovf_o), 32'd0);
      @(negedge clk); idle();
      #2;
      chk("R8 cwp", 32'(cwp_o), 32'd3);

      // R1: mid-run reset clears pointer and contents
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      rst_n = 1'b1;
      rd_a_idx = 5'd3; rd_b_idx = 5'd28;
      #1;
      chk("R1 cwp after reset", 32'(cwp_o), 32'd0);
      chk("R1 global cleared", rd_a_data, 32'd0);
      chk("R1 window cleared", rd_b_data, 32'd0);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule